// File: doc/BRIEF.md
# Exposure Step Loader

This block sets the exposure of a CCD camera timing generator while it runs in electronic-shutter mode. It shares three input pins: a serial clock, a serial data line and a strobe. A select input decides how those pins are read. In serial mode, an 8-bit code is shifted in most significant bit first, one bit on each rising edge of the clock pin. The code takes effect only when the strobe pin rises. In parallel mode, the levels on the three pins pick one of eight fixed speeds, and a standard-select input chooses the 525-line table or the 625-line table.

The block outputs an 8-bit exposure step count for the discharge-pulse generator. The count is 255 minus the loaded code, so an all-ones code means no extra shutter. While the shutter is disabled, or while the iris loop owns the pins, the count is zero, which gives the field-rate exposure. Each pin passes through a two-flop synchronizer and an edge detector in the system clock domain. A three-state controller picks the source of the output:
- States: `SM_OFF`, `SM_SERIAL`, `SM_PARALLEL`.
- Transitions: `T_DISABLE` takes any state to `SM_OFF` when enable is low or iris mode is high. `T_TO_SERIAL` moves to `SM_SERIAL` when the shutter is allowed and select is low. `T_TO_PARALLEL` moves to `SM_PARALLEL` when the shutter is allowed and select is high. `T_HOLD` keeps the current state.

Top module: `shutter_step_loader`

## Requirements
- R1: After reset, `step_o` is 0 and the committed code is 8'hFF. Entering serial mode with nothing loaded therefore still gives 0 steps.
- R2: In serial mode, each rising edge of `pin_clk_i` shifts `pin_dat_i` into the low bit of the shift register. The word is sent most significant bit first, and only the last 8 bits sent are kept.
- R3: A shifted word changes `step_o` only after a rising edge of `pin_stb_i` in serial mode. Shifting without a strobe leaves `step_o` unchanged.
- R4: In serial mode, `step_o` equals 255 minus the committed code. For example, 8'hC2 gives 61 and 8'h6A gives 149.
- R5: Serial mode is used when `par_sel_i` is 0, and parallel mode when `par_sel_i` is 1.
- R6: `step_o` is 0 whenever `enable_i` is 0 or `iris_mode_i` is 1.
- R7: In parallel mode with `std_625_i` = 0, the index {dat,clk,stb} maps as follows: 7→9, 6→26, 5→45, 4→61, 3→71, 2→87, 1→100, 0→149.
- R8: In parallel mode with `std_625_i` = 1, the same index maps as follows: 7→14, 6→28, 5→47, 4→63, 3→72, 2→89, 1→103, 0→151.
- R9: Clock and strobe edges that arrive outside serial mode change neither the shift register nor the committed code.
- R10: Suppose `pin_stb_i` rises between two clock edges. The newly committed value appears on `step_o` after the fourth following rising edge of `clk`, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Shutter allowed when high |
| iris_mode_i | input | 1 | Iris loop owns the pins when high (no shutter step) |
| par_sel_i | input | 1 | 0: serial load, 1: parallel pin decode |
| std_625_i | input | 1 | 0: 525-line table, 1: 625-line table |
| pin_clk_i | input | 1 | Serial clock pin / parallel index bit 1 |
| pin_dat_i | input | 1 | Serial data pin / parallel index bit 2 |
| pin_stb_i | input | 1 | Strobe pin / parallel index bit 0 |
| step_o | output | 8 | Exposure step count |

## Verification
The assertions assume three things about the inputs:
- The mode inputs (`enable_i`, `iris_mode_i`, `par_sel_i`) are quasi-static.
- A data bit is stable for several system clocks around each clock-pin rise.
- The clock pin and the strobe pin never rise in the same synchronized cycle.

The stimulus respects all three. It changes a pin only just after a falling system-clock edge, and it keeps every pin level for at least four cycles. It changes data only while the clock pin is low, and it strobes only after the clock pin has settled low.

// File: rtl/shutter_load_pkg.sv
package shutter_load_pkg;

    typedef enum logic [1:0] {
        SM_OFF      = 2'd0,
        SM_SERIAL   = 2'd1,
        SM_PARALLEL = 2'd2
    } load_state_e;

    localparam int PIN_N   = 3;
    localparam int PIN_STB = 0;
    localparam int PIN_CLK = 1;
    localparam int PIN_DAT = 2;

    // Fixed speed table, stored as step counts matching the serial encoding.
    function automatic logic [7:0] par_steps(input logic is625, input logic [2:0] idx);
        logic [7:0] v;
        if (!is625) begin
            unique case (idx)
                3'd7: v = 8'd9;
                3'd6: v = 8'd26;
                3'd5: v = 8'd45;
                3'd4: v = 8'd61;
                3'd3: v = 8'd71;
                3'd2: v = 8'd87;
                3'd1: v = 8'd100;
                default: v = 8'd149;
            endcase
        end else begin
            unique case (idx)
                3'd7: v = 8'd14;
                3'd6: v = 8'd28;
                3'd5: v = 8'd47;
                3'd4: v = 8'd63;
                3'd3: v = 8'd72;
                3'd2: v = 8'd89;
                3'd1: v = 8'd103;
                default: v = 8'd151;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    localparam int LAST = STAGES - 1;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pin
            logic [STAGES-1:0] chain_q;
            logic              prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                    prev_q  <= 1'b0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], pins_i[g]};
                    prev_q  <= chain_q[LAST];
                end
            end

            assign level_o[g] = chain_q[LAST];
            assign rise_o[g]  = chain_q[LAST] & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         bit_rise_i,
    input  logic         bit_i,
    input  logic         commit_i,
    output logic [W-1:0] shift_o,
    output logic [W-1:0] hold_o
);
    logic [W-1:0] shift_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            hold_q  <= '1;
        end else if (active_i) begin
            if (bit_rise_i) shift_q <= {shift_q[W-2:0], bit_i};
            if (commit_i)   hold_q  <= shift_q;
        end
    end

    assign shift_o = shift_q;
    assign hold_o  = hold_q;
endmodule

// File: rtl/par_decode.sv
module par_decode #(
    parameter int W = 8
) (
    input  logic         is625_i,
    input  logic [2:0]   idx_i,
    output logic [W-1:0] steps_o
);
    import shutter_load_pkg::*;

    always_comb begin
        steps_o = W'(par_steps(is625_i, idx_i));
    end
endmodule

// File: rtl/shutter_step_loader.sv
module shutter_step_loader #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              iris_mode_i,
    input  logic              par_sel_i,
    input  logic              std_625_i,
    input  logic              pin_clk_i,
    input  logic              pin_dat_i,
    input  logic              pin_stb_i,
    output logic [WORD_W-1:0] step_o
);
    import shutter_load_pkg::*;

    localparam logic [WORD_W-1:0] CODE_MAX = {WORD_W{1'b1}};

    logic [PIN_N-1:0]  pin_lvl;
    logic [PIN_N-1:0]  pin_rise;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] par_val;
    logic              clk_rise;
    logic              stb_rise;
    logic              dat_lvl;
    logic              in_serial;

    load_state_e state_q, state_d;

    pin_sync #(.N(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  ({pin_dat_i, pin_clk_i, pin_stb_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    assign clk_rise  = pin_rise[PIN_CLK];
    assign stb_rise  = pin_rise[PIN_STB];
    assign dat_lvl   = pin_lvl[PIN_DAT];
    assign in_serial = (state_q == SM_SERIAL);

    serial_shifter #(.W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (in_serial),
        .bit_rise_i (clk_rise),
        .bit_i      (dat_lvl),
        .commit_i   (stb_rise),
        .shift_o    (shift_q),
        .hold_o     (hold_q)
    );

    par_decode #(.W(WORD_W)) u_par (
        .is625_i (std_625_i),
        .idx_i   ({pin_lvl[PIN_DAT], pin_lvl[PIN_CLK], pin_lvl[PIN_STB]}),
        .steps_o (par_val)
    );

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SM_OFF: begin
                if (enable_i && !iris_mode_i)
                    state_d = par_sel_i ? SM_PARALLEL : SM_SERIAL;
            end
            SM_SERIAL: begin
                if (!enable_i || iris_mode_i) state_d = SM_OFF;
                else if (par_sel_i)           state_d = SM_PARALLEL;
            end
            SM_PARALLEL: begin
                if (!enable_i || iris_mode_i) state_d = SM_OFF;
                else if (!par_sel_i)          state_d = SM_SERIAL;
            end
            default: state_d = SM_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SM_OFF;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_o <= '0;
        end else begin
            unique case (state_q)
                SM_SERIAL:   step_o <= CODE_MAX - hold_q;
                SM_PARALLEL: step_o <= par_val;
                default:     step_o <= '0;
            endcase
        end
    end
endmodule

// File: rtl/shutter_step_loader_chk.sv
module shutter_step_loader_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              iris_mode_i,
    input logic              par_sel_i,
    input logic [1:0]        state_q,
    input logic              clk_rise,
    input logic              stb_rise,
    input logic              dat_lvl,
    input logic [WORD_W-1:0] shift_q,
    input logic [WORD_W-1:0] hold_q,
    input logic [WORD_W-1:0] step_o
);
    import shutter_load_pkg::*;

    localparam logic [WORD_W-1:0] CODE_MAX = {WORD_W{1'b1}};

    a_r2_shift_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_q != $past(shift_q)) |-> ($past(clk_rise) && $past(state_q) == SM_SERIAL));

    a_r2_shift_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rise && state_q == SM_SERIAL) |=> (shift_q[0] == $past(dat_lvl)));

    a_r3_commit_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != $past(hold_q)) |-> ($past(stb_rise) && $past(state_q) == SM_SERIAL));

    a_r4_serial_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == SM_SERIAL) |-> (step_o == CODE_MAX - $past(hold_q)));

    a_r5_parallel_select: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SM_PARALLEL) |-> $past(par_sel_i));

    a_r6_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o != '0) |-> ($past(enable_i, 2) && !$past(iris_mode_i, 2)));
endmodule

bind shutter_step_loader shutter_step_loader_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .iris_mode_i (iris_mode_i),
    .par_sel_i   (par_sel_i),
    .state_q     (state_q),
    .clk_rise    (clk_rise),
    .stb_rise    (stb_rise),
    .dat_lvl     (dat_lvl),
    .shift_q     (shift_q),
    .hold_q      (hold_q),
    .step_o      (step_o)
);

// File: tb/shutter_step_loader_tb.sv
module shutter_step_loader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       iris_mode_i = 1'b0;
    logic       par_sel_i = 1'b0;
    logic       std_625_i = 1'b0;
    logic       pin_clk_i = 1'b0;
    logic       pin_dat_i = 1'b0;
    logic       pin_stb_i = 1'b0;
    logic [7:0] step_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    shutter_step_loader u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .iris_mode_i(iris_mode_i),
        .par_sel_i(par_sel_i), .std_625_i(std_625_i), .pin_clk_i(pin_clk_i),
        .pin_dat_i(pin_dat_i), .pin_stb_i(pin_stb_i), .step_o(step_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clk();
        pin_clk_i = 1'b1; idle(4);
        pin_clk_i = 1'b0; idle(4);
    endtask

    task automatic pulse_stb();
        pin_stb_i = 1'b1; idle(4);
        pin_stb_i = 1'b0; idle(4);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            pin_dat_i = w[i];
            idle(2);
            pulse_clk();
        end
    endtask

    task automatic load_word(input logic [7:0] w);
        shift_bits({8'h00, w}, 8);
        pulse_stb();
        idle(2);
    endtask

    function automatic int exp_par(input bit is625, input int idx);
        int e525[8] = '{149, 100, 87, 71, 61, 45, 26, 9};
        int e625[8] = '{151, 103, 89, 72, 63, 47, 28, 14};
        return is625 ? e625[idx] : e525[idx];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R1 reset step", step_o, 0);
        rst_n = 1'b1;
        idle(3);
        check("R6 enable low gives zero", step_o, 0);

        // R1: serial mode with nothing loaded: code FF -> 0 steps
        enable_i = 1'b1;
        idle(4);
        check("R1 reset code FF", step_o, 0);

        // R4 examples
        load_word(8'hC2);
        check("R4 C2 gives 61", step_o, 61);
        load_word(8'h6A);
        check("R4 6A gives 149", step_o, 149);

        // R2: nine bits sent, only the last eight kept (MSB first)
        shift_bits(16'h0135, 9);
        pulse_stb(); idle(2);
        check("R2 last eight bits kept", step_o, 255 - 8'h35);

        // R3: shifting without a strobe does not change the output
        shift_bits(16'h0011, 8);
        idle(4);
        check("R3 no strobe no change", step_o, 255 - 8'h35);

        // R10: strobe-to-output latency
        pin_stb_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 not before fourth edge", step_o, 255 - 8'h35);
        @(posedge clk);
        @(negedge clk);
        check("R10 at fourth edge", step_o, 255 - 8'h11);
        pin_stb_i = 1'b0;
        idle(4);

        // R6: iris mode forces zero steps
        iris_mode_i = 1'b1; idle(4);
        check("R6 iris mode zero", step_o, 0);
        iris_mode_i = 1'b0; idle(4);
        check("R6 back to serial keeps code", step_o, 255 - 8'h11);

        // R9: edges in parallel mode and in off mode are ignored
        par_sel_i = 1'b1; idle(4);
        shift_bits(16'h0044, 8);
        pulse_stb();
        pin_dat_i = 1'b0;
        par_sel_i = 1'b0; idle(4);
        check("R9 parallel edges ignored", step_o, 255 - 8'h11);
        enable_i = 1'b0; idle(4);
        shift_bits(16'h0077, 8);
        pulse_stb();
        pin_dat_i = 1'b0;
        enable_i = 1'b1; idle(4);
        check("R9 off-mode edges ignored", step_o, 255 - 8'h11);
        pulse_stb();
        check("R9 shift register untouched", step_o, 255 - 8'h11);

        // R4/R2: exhaustive serial sweep
        for (int c = 0; c < 256; c++) begin
            load_word(8'(c));
            check("R4 R2 serial sweep", step_o, 255 - c);
        end

        // R5, R7, R8: parallel decode in both standards
        par_sel_i = 1'b1;
        for (int s = 0; s < 2; s++) begin
            std_625_i = s[0];
            for (int i = 0; i < 8; i++) begin
                pin_stb_i = i[0];
                pin_clk_i = i[1];
                pin_dat_i = i[2];
                idle(6);
                check(s == 0 ? "R5 R7 parallel 525" : "R5 R8 parallel 625",
                      step_o, exp_par(s[0], i));
            end
        end
        pin_stb_i = 1'b0; pin_clk_i = 1'b0; pin_dat_i = 1'b0;
        enable_i = 1'b0; idle(4);
        check("R6 parallel disabled zero", step_o, 0);
        enable_i = 1'b1; par_sel_i = 1'b0; idle(4);
        check("R5 serial reselected", step_o, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule